// File: doc/BRIEF.md
# Interlaced Composite Video Sync Generator

This block builds every timing signal an interlaced 2:1 raster needs. It supports two line standards: a 525-line frame and a 625-line frame. A master clock enable paces a horizontal tick counter. A second counter tracks the vertical position in half-line steps, so each frame is 1050 or 1250 steps long. Working in half-lines puts the half-line offset between the two fields, and the double-rate pulses of the vertical interval, on whole counts.

All outputs are decoded from these two counters and registered on the clock. They are:
- composite sync, with equalizing pulses and serrated broad pulses;
- horizontal drive and a back-porch clamp;
- vertical drive and short vertical drive;
- horizontal, vertical, mixed processing and beam blanking;
- a pulse that marks the start of the odd field.

A vertical reset strobe re-aligns the vertical counter to a point chosen by a select input. The two points are the first equalizing pulse and the first broad pulse. The line-standard input takes effect only at a frame boundary.

Top module: `vsg_sync_gen`

## Requirements
- R1: While rst_n is low at a clock edge, every output is low. The counters restart at tick 0 and half-line 0, and the line standard is taken from mode625_i.
- R2: A line lasts LINE_TICKS enabled ticks. Outside the vertical interval, csync_o is high for the first HSYNC_W ticks of each line. A frame holds (lines − 18) such pulses.
- R3: Half-lines 0–5 and 12–17 of each field are equalizing pulses. In each of them, csync_o is high for HSYNC_W/2 ticks from the start of the half-line, which gives 12 per field. The odd field opens with such a pulse.
- R4: Half-lines 6–11 of each field are broad pulses. csync_o is high for HALF−HSYNC_W ticks and low for the last HSYNC_W ticks of each half-line. HALF is LINE_TICKS/2.
- R5: A frame is 1050 half-lines when mode625_i=0 and 1250 when it is 1. The even field starts at half-line 525 or 625, so in 525-line mode its vertical interval begins mid-line.
- R6: frame_o is high for exactly the half-line 0 of each frame and at no other time.
- R7: mode625_i is sampled only when the vertical counter wraps at the end of a frame.
- R8: A one-cycle vreset_i arms a load. At the next half-line boundary, the vertical counter is loaded with 0 (vreset_sel_i=0, first equalizing pulse) or 6 (vreset_sel_i=1, first broad pulse) instead of stepping. The tick counter is not touched and the line standard is not resampled.
- R9: hdrive_o is high for ticks h < HDRIVE_W. hclamp_o is high for HSYNC_W ≤ h < HSYNC_W+CLAMP_W.
- R10: vdrive_o is high for field half-lines 0–17. vdrive_short_o is high for field half-lines 6–11.
- R11: hblank_proc_o is high for h ≥ LINE_TICKS−FPORCH_W or h < HBLANK_W−FPORCH_W. vblank_proc_o is high for field half-lines below 2·VBLANK_LINES. mblank_proc_o is the OR of the two. mblank_beam_o is vertical blanking OR the horizontal window widened by BEAM_EXT ticks on each side.
- R12: Outputs are registered and show the counter state one clock later. When ce_i is low, the counters hold, and from the next clock the outputs stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_i | input | 1 | Master clock enable, one tick per high cycle |
| mode625_i | input | 1 | Line standard: 0 = 525 lines, 1 = 625 lines |
| vreset_i | input | 1 | Vertical reset strobe |
| vreset_sel_i | input | 1 | Reset point: 0 = first equalizing pulse, 1 = first broad pulse |
| csync_o | output | 1 | Composite sync, high during sync tips |
| hdrive_o | output | 1 | Horizontal drive |
| hclamp_o | output | 1 | Horizontal clamp pulse |
| vdrive_o | output | 1 | Vertical drive |
| vdrive_short_o | output | 1 | Short vertical drive |
| hblank_proc_o | output | 1 | Horizontal processing blanking |
| vblank_proc_o | output | 1 | Vertical processing blanking |
| mblank_proc_o | output | 1 | Mixed processing blanking |
| mblank_beam_o | output | 1 | Mixed beam blanking |
| frame_o | output | 1 | Odd-field frame pulse |

## Verification
Every output is due one clock after the counter state it decodes. The bench evaluates its behavioural model at the rising edge, from the model state held before that edge, and compares against the outputs at the following falling edge.

A vertical reset strobe shows its effect between 2 and HALF+1 clocks later, depending on where the next half-line boundary falls. The bench accepts exactly that window.

A change of line standard is first visible in the frame after the running one. Frame-length checks therefore measure the frame in which the change was made and then the frame after it.

// File: rtl/vsg_pkg.sv
// Package: shared constants and output bundle of the sync generator.
// Assumes the vertical counter runs in half-line units from the first
// equalizing pulse of the odd field.
package vsg_pkg;

    localparam int V_W           = 11;
    localparam int HL_FRAME_525  = 1050;
    localparam int HL_FRAME_625  = 1250;
    localparam int VS_START      = 6;   // first broad pulse half-line
    localparam int EQ_POST_START = 12;  // first post-equalizing half-line
    localparam int VINT_END      = 18;  // first half-line after interval

    typedef struct packed {
        logic csync;
        logic hdrive;
        logic hclamp;
        logic vdrive;
        logic vdrive_short;
        logic hblank;
        logic vblank;
        logic mblank_proc;
        logic mblank_beam;
        logic frame;
    } vsg_out_t;

    // Number of half-lines in one frame for the chosen line standard.
    function automatic logic [V_W-1:0] frame_halflines(input logic is625);
        return is625 ? V_W'(HL_FRAME_625) : V_W'(HL_FRAME_525);
    endfunction

endpackage

// File: rtl/vsg_hcount.sv
// Module: horizontal tick counter.
// Counts enabled ticks 0..LINE_TICKS-1 and flags each half-line boundary.
// Assumes LINE_TICKS is even.
module vsg_hcount #(
    parameter int  LINE_TICKS = 64,
    localparam int H_W        = $clog2(LINE_TICKS),
    localparam int HALF       = LINE_TICKS / 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ce_i,
    output logic [H_W-1:0] h_o,
    output logic           step_o
);

    logic [H_W-1:0] h_q;

    // Advance the tick position on every enabled cycle, wrapping per line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q <= '0;
        end else if (ce_i) begin
            h_q <= (h_q == H_W'(LINE_TICKS - 1)) ? '0 : h_q + 1'b1;
        end
    end

    // Flag the last tick of each half-line so the vertical counter steps.
    always_comb begin
        step_o = ce_i && ((h_q == H_W'(HALF - 1)) || (h_q == H_W'(LINE_TICKS - 1)));
    end

    assign h_o = h_q;

    // R2: the line restarts after its last tick
    a_r2_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_i && h_q == H_W'(LINE_TICKS - 1)) |=> (h_q == '0));

    // R12: without a tick enable the horizontal position holds
    a_r12_hold_h: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_i) |=> $stable(h_q));

endmodule

// File: rtl/vsg_vcount.sv
// Module: half-line vertical counter with line-standard latch and
// armed vertical reset.
// Assumes step_i pulses for one cycle at each half-line boundary.
module vsg_vcount
    import vsg_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           step_i,
    input  logic           mode625_i,
    input  logic           vreset_i,
    input  logic           vreset_sel_i,
    output logic [V_W-1:0] v_o,
    output logic           mode_o
);

    logic [V_W-1:0] v_q;
    logic           mode_q;
    logic           pend_q;
    logic           sel_q;
    logic [V_W-1:0] last_hl;

    // Index of the final half-line of a frame in the latched standard.
    always_comb begin
        last_hl = frame_halflines(mode_q) - 1'b1;
    end

    // Arm a vertical reset and remember its target until the next boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            sel_q  <= 1'b0;
        end else if (vreset_i) begin
            pend_q <= 1'b1;
            sel_q  <= vreset_sel_i;
        end else if (step_i) begin
            pend_q <= 1'b0;
        end
    end

    // Step, wrap or load the half-line position; latch the standard at wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q    <= '0;
            mode_q <= mode625_i;
        end else if (step_i) begin
            if (pend_q) begin
                v_q <= sel_q ? V_W'(VS_START) : '0;
            end else if (v_q == last_hl) begin
                v_q    <= '0;
                mode_q <= mode625_i;
            end else begin
                v_q <= v_q + 1'b1;
            end
        end
    end

    assign v_o    = v_q;
    assign mode_o = mode_q;

    // R7: the standard only changes as a new frame begins
    a_r7_mode_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(mode_q)) |-> (v_q == '0));

    // R8: an armed reset with select 0 lands on the first equalizing pulse
    a_r8_to_first_eq: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && pend_q && !sel_q) |=> (v_q == '0));

    // R8: an armed reset with select 1 lands on the first broad pulse
    a_r8_to_first_vs: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && pend_q && sel_q) |=> (v_q == V_W'(VS_START)));

endmodule

// File: rtl/vsg_decode.sv
// Module: output decoder and retiming register.
// Turns tick and half-line positions into sync, drive and blanking
// pulses and registers them on the master clock.
// Assumes HSYNC_W is even and VBLANK_LINES covers the vertical interval.
module vsg_decode
    import vsg_pkg::*;
#(
    parameter int  LINE_TICKS   = 64,
    parameter int  HSYNC_W      = 4,
    parameter int  HDRIVE_W     = 6,
    parameter int  CLAMP_W      = 4,
    parameter int  FPORCH_W     = 2,
    parameter int  HBLANK_W     = 12,
    parameter int  BEAM_EXT     = 1,
    parameter int  VBLANK_LINES = 20,
    localparam int H_W          = $clog2(LINE_TICKS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [H_W-1:0] h_i,
    input  logic [V_W-1:0] v_i,
    input  logic           mode_i,
    output vsg_out_t       out_o
);

    localparam int HALF     = LINE_TICKS / 2;
    localparam int EQ_W     = HSYNC_W / 2;
    localparam int BROAD_W  = HALF - HSYNC_W;
    localparam int HB_START = LINE_TICKS - FPORCH_W;
    localparam int HB_END   = HBLANK_W - FPORCH_W;
    localparam int VBL_HL   = 2 * VBLANK_LINES;

    vsg_out_t nxt;
    vsg_out_t out_q;
    int       hi;
    int       hp;
    int       vi;
    int       vf;
    int       half_frame;
    logic     in_eq;
    logic     in_vs;

    // Decode the current positions into the next output values.
    always_comb begin
        hi         = int'(h_i);
        vi         = int'(v_i);
        hp         = (hi < HALF) ? hi : hi - HALF;
        half_frame = int'(frame_halflines(mode_i)) / 2;
        vf         = (vi < half_frame) ? vi : vi - half_frame;
        in_eq      = (vf < VS_START) || ((vf >= EQ_POST_START) && (vf < VINT_END));
        in_vs      = (vf >= VS_START) && (vf < EQ_POST_START);

        if (in_eq) begin
            nxt.csync = (hp < EQ_W);
        end else if (in_vs) begin
            nxt.csync = (hp < BROAD_W);
        end else begin
            nxt.csync = (hi < HSYNC_W);
        end

        nxt.hdrive       = (hi < HDRIVE_W);
        nxt.hclamp       = (hi >= HSYNC_W) && (hi < HSYNC_W + CLAMP_W);
        nxt.vdrive       = (vf < VINT_END);
        nxt.vdrive_short = in_vs;
        nxt.hblank       = (hi >= HB_START) || (hi < HB_END);
        nxt.vblank       = (vf < VBL_HL);
        nxt.mblank_proc  = nxt.hblank || nxt.vblank;
        nxt.mblank_beam  = nxt.vblank || (hi >= HB_START - BEAM_EXT)
                           || (hi < HB_END + BEAM_EXT);
        nxt.frame        = (vi == 0);
    end

    // Retime every output to the master clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= nxt;
        end
    end

    assign out_o = out_q;

    // R3: the odd field opens on an equalizing pulse
    a_r3_field_opens_with_eq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_q.frame) |-> out_q.csync);

    // R10: short vertical drive lies inside vertical drive and blanking
    a_r10_vs_inside_vblank: assert property (@(posedge clk) disable iff (!rst_n)
        out_q.vdrive_short |-> (out_q.vblank && out_q.vdrive));

endmodule

// File: rtl/vsg_sync_gen.sv
// Module: top of the interlaced composite sync generator.
// Ties the tick counter, half-line counter and decoder together.
// Assumes ce_i is the only pacing of the raster.
module vsg_sync_gen
    import vsg_pkg::*;
#(
    parameter int LINE_TICKS   = 64,
    parameter int HSYNC_W      = 4,
    parameter int HDRIVE_W     = 6,
    parameter int CLAMP_W      = 4,
    parameter int FPORCH_W     = 2,
    parameter int HBLANK_W     = 12,
    parameter int BEAM_EXT     = 1,
    parameter int VBLANK_LINES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_i,
    input  logic mode625_i,
    input  logic vreset_i,
    input  logic vreset_sel_i,
    output logic csync_o,
    output logic hdrive_o,
    output logic hclamp_o,
    output logic vdrive_o,
    output logic vdrive_short_o,
    output logic hblank_proc_o,
    output logic vblank_proc_o,
    output logic mblank_proc_o,
    output logic mblank_beam_o,
    output logic frame_o
);

    localparam int H_W = $clog2(LINE_TICKS);

    logic [H_W-1:0] h;
    logic           step;
    logic [V_W-1:0] v;
    logic           mode;
    vsg_out_t       outs;

    vsg_hcount #(
        .LINE_TICKS(LINE_TICKS)
    ) u_hcount (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_i   (ce_i),
        .h_o    (h),
        .step_o (step)
    );

    vsg_vcount u_vcount (
        .clk          (clk),
        .rst_n        (rst_n),
        .step_i       (step),
        .mode625_i    (mode625_i),
        .vreset_i     (vreset_i),
        .vreset_sel_i (vreset_sel_i),
        .v_o          (v),
        .mode_o       (mode)
    );

    vsg_decode #(
        .LINE_TICKS   (LINE_TICKS),
        .HSYNC_W      (HSYNC_W),
        .HDRIVE_W     (HDRIVE_W),
        .CLAMP_W      (CLAMP_W),
        .FPORCH_W     (FPORCH_W),
        .HBLANK_W     (HBLANK_W),
        .BEAM_EXT     (BEAM_EXT),
        .VBLANK_LINES (VBLANK_LINES)
    ) u_decode (
        .clk    (clk),
        .rst_n  (rst_n),
        .h_i    (h),
        .v_i    (v),
        .mode_i (mode),
        .out_o  (outs)
    );

    assign csync_o        = outs.csync;
    assign hdrive_o       = outs.hdrive;
    assign hclamp_o       = outs.hclamp;
    assign vdrive_o       = outs.vdrive;
    assign vdrive_short_o = outs.vdrive_short;
    assign hblank_proc_o  = outs.hblank;
    assign vblank_proc_o  = outs.vblank;
    assign mblank_proc_o  = outs.mblank_proc;
    assign mblank_beam_o  = outs.mblank_beam;
    assign frame_o        = outs.frame;

endmodule

// File: tb/vsg_sync_gen_tb_top.sv
module vsg_sync_gen_tb_top;

    localparam int LT   = 64;
    localparam int HALF = LT / 2;
    localparam int HS   = 4;
    localparam int HD   = 6;
    localparam int CL   = 4;
    localparam int FP   = 2;
    localparam int HB   = 12;
    localparam int BX   = 1;
    localparam int VBL  = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce = 1'b1;
    logic mode = 1'b0;
    logic vrst = 1'b0;
    logic vsel = 1'b0;

    logic csync_o, hdrive_o, hclamp_o, vdrive_o, vdrive_short_o;
    logic hblank_proc_o, vblank_proc_o, mblank_proc_o, mblank_beam_o, frame_o;

    int n_chk = 0;
    int n_err = 0;
    logic cmp_on = 1'b0;

    // behavioural model state
    int mh, mv, mm, mp, ms, bnd;
    logic e_cs, e_hd, e_hc, e_vd, e_vs, e_hb, e_vb, e_mp, e_mb, e_fr;

    always #10 clk = ~clk;

    vsg_sync_gen #(
        .LINE_TICKS(LT), .HSYNC_W(HS), .HDRIVE_W(HD), .CLAMP_W(CL),
        .FPORCH_W(FP), .HBLANK_W(HB), .BEAM_EXT(BX), .VBLANK_LINES(VBL)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_i(ce), .mode625_i(mode),
        .vreset_i(vrst), .vreset_sel_i(vsel),
        .csync_o(csync_o), .hdrive_o(hdrive_o), .hclamp_o(hclamp_o),
        .vdrive_o(vdrive_o), .vdrive_short_o(vdrive_short_o),
        .hblank_proc_o(hblank_proc_o), .vblank_proc_o(vblank_proc_o),
        .mblank_proc_o(mblank_proc_o), .mblank_beam_o(mblank_beam_o),
        .frame_o(frame_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected outputs from the requirement text, given positions h, v.
    task automatic expect_from(input int h, input int v, input int m);
        int hf, vf, hp;
        hf = (m != 0) ? 625 : 525;
        vf = (v >= hf) ? v - hf : v;
        hp = h % HALF;
        if (vf < 6 || (vf >= 12 && vf < 18)) e_cs = (hp < HS / 2);
        else if (vf < 12)                     e_cs = (hp < HALF - HS);
        else                                  e_cs = (h < HS);
        e_hd = (h < HD);
        e_hc = (h >= HS && h < HS + CL);
        e_vd = (vf < 18);
        e_vs = (vf >= 6 && vf < 12);
        e_hb = (h >= LT - FP || h < HB - FP);
        e_vb = (vf < 2 * VBL);
        e_mp = e_hb | e_vb;
        e_mb = e_vb | (h >= LT - FP - BX) | (h < HB - FP + BX);
        e_fr = (v == 0);
    endtask

    // Reference model: evaluate then advance, once per clock.
    always @(posedge clk) begin
        cmp_on <= 1'b1;
        if (!rst_n) begin
            {e_cs, e_hd, e_hc, e_vd, e_vs, e_hb, e_vb, e_mp, e_mb, e_fr} = '0;
            mh = 0; mv = 0; mm = mode; mp = 0; ms = 0;
        end else begin
            expect_from(mh, mv, mm);
            if (ce) begin
                bnd = (mh == HALF - 1 || mh == LT - 1) ? 1 : 0;
                mh = (mh + 1) % LT;
                if (bnd != 0) begin
                    if (mp != 0) begin
                        mv = (ms != 0) ? 6 : 0;
                        mp = 0;
                    end else if (mv == ((mm != 0) ? 1249 : 1049)) begin
                        mv = 0;
                        mm = mode;
                    end else begin
                        mv = mv + 1;
                    end
                end
            end
            if (vrst) begin
                mp = 1;
                ms = vsel;
            end
        end
    end

    // Compare every output with the model, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R2,R3,R4,R12 csync", csync_o, e_cs);
            chk("R9 hdrive", hdrive_o, e_hd);
            chk("R9 hclamp", hclamp_o, e_hc);
            chk("R10 vdrive", vdrive_o, e_vd);
            chk("R10 vdrive_short", vdrive_short_o, e_vs);
            chk("R11 hblank", hblank_proc_o, e_hb);
            chk("R11 vblank", vblank_proc_o, e_vb);
            chk("R11 mblank_proc", mblank_proc_o, e_mp);
            chk("R11 mblank_beam", mblank_beam_o, e_mb);
            chk("R6 frame", frame_o, e_fr);
        end
    end

    // Measure one frame starting at a frame_o rise; optional mode flip.
    task automatic measure(input int hl, input int flip_at, input string tag);
        int n, run, neq, nbr, nnorm, nother, fhi, vdr, vd2;
        logic pcs, pfr, pvd, done;
        n = 0; run = 1; neq = 0; nbr = 0; nnorm = 0; nother = 0;
        fhi = 1; vdr = 1; vd2 = -1; done = 1'b0;
        pcs = csync_o; pfr = frame_o; pvd = vdrive_o;
        while (!done) begin
            @(negedge clk);
            n++;
            if (n == flip_at) mode = ~mode;
            if (frame_o && !pfr) begin
                done = 1'b1;
            end else begin
                if (frame_o) fhi++;
                if (vdrive_o && !pvd) begin
                    vdr++;
                    if (vdr == 2) vd2 = n;
                end
                if (csync_o && !pcs) run = 1;
                else if (csync_o) run++;
                else if (pcs) begin
                    if (run == HS / 2)          neq++;
                    else if (run == HALF - HS)  nbr++;
                    else if (run == HS)         nnorm++;
                    else                        nother++;
                end
                pcs = csync_o; pfr = frame_o; pvd = vdrive_o;
            end
        end
        chk({tag, " R5 frame length"}, n, hl * HALF);
        chk("R3 equalizing pulses per frame", neq, 24);
        chk("R4 broad pulses per frame", nbr, 12);
        chk("R2 line sync pulses per frame", nnorm, hl / 2 - 18);
        chk("R2 unexpected sync widths", nother, 0);
        chk("R6 frame pulse width", fhi, HALF);
        chk("R5 even field offset", vd2, (hl / 2) * HALF);
    endtask

    initial begin
        int k;
        logic [9:0] snap;
        repeat (5) @(negedge clk);
        chk("R1 reset outputs", {csync_o, hdrive_o, hclamp_o, vdrive_o, vdrive_short_o,
            hblank_proc_o, vblank_proc_o, mblank_proc_o, mblank_beam_o, frame_o}, 0);
        rst_n = 1'b1;
        k = 0;
        while (!frame_o && k < 10) begin
            @(negedge clk);
            k++;
        end
        chk("R1 first frame pulse after reset", k, 1);

        // 525 frame; standard flipped early, must not apply yet (R7)
        measure(1050, 100, "R7 flip held");
        measure(1250, -1, "R5 625");

        // R8 reset to first equalizing pulse
        repeat (100) @(negedge clk);
        vsel = 1'b0; vrst = 1'b1;
        @(negedge clk);
        vrst = 1'b0;
        k = 0;
        while (!frame_o && k < 2 * HALF) begin
            @(negedge clk);
            k++;
        end
        chk("R8 sel0 lands in window", (k >= 2 && k <= HALF + 1) ? 1 : 0, 1);

        // R8 reset to first broad pulse
        repeat (HALF + 10) @(negedge clk);
        vsel = 1'b1; vrst = 1'b1;
        @(negedge clk);
        vrst = 1'b0;
        k = 0;
        while (!vdrive_short_o && k < 2 * HALF) begin
            @(negedge clk);
            k++;
        end
        chk("R8 sel1 lands in window", (k >= 2 && k <= HALF + 1) ? 1 : 0, 1);
        chk("R8 sel1 not at field start", frame_o, 0);

        // R12 outputs freeze while enable is low
        repeat (7) @(negedge clk);
        ce = 1'b0;
        @(negedge clk);
        @(negedge clk);
        snap = {csync_o, hdrive_o, hclamp_o, vdrive_o, vdrive_short_o,
                hblank_proc_o, vblank_proc_o, mblank_proc_o, mblank_beam_o, frame_o};
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk("R12 hold with ce low", {csync_o, hdrive_o, hclamp_o, vdrive_o,
                vdrive_short_o, hblank_proc_o, vblank_proc_o, mblank_proc_o,
                mblank_beam_o, frame_o}, snap);
        end

        // R12 gated enable pattern, checked by the model
        for (int i = 0; i < 3000; i++) begin
            ce = (i % 3 != 0);
            @(negedge clk);
        end
        ce = 1'b1;
        repeat (20) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule